// File: doc/BRIEF.md
# Guarded Overflow Timer with Control/Status Register

The block is an 8-bit up-counter clocked by enable pulses from a free-running prescaler. It serves either as an interval timer or as a watchdog. One 8-bit control/status register holds five fields:

- an overflow flag;
- a mode bit;
- a run bit;
- two fixed reserved bits;
- a 3-bit tap select that chooses the prescaler ratio.

Software reaches the register and the counter over a simple synchronous bus with a one-bit address, read and write strobes, 16-bit write data and 8-bit read data. The upper byte of each write is a key. A write whose key is wrong has no effect.

When the counter wraps from 0xFF to 0x00, the overflow flag sets. In interval mode the flag drives a level interrupt request. In watchdog mode the block instead emits a one-cycle reset request. The flag is hard to clear by accident: software must first read the register while the flag is 1, and only a later write of 0 clears it. A standby input clears the flag, the mode bit and the run bit, and keeps the tap select.

Top module: `guard_timer`

## Requirements
- R1: After a synchronous reset, the control/status register (address 0) reads 0x10, the counter (address 1) reads 0x00, and both irq_o and rst_req_o are 0.
- R2: A write to address 0 takes effect only when wdata[15:8] is 0xA5. It then loads mode (bit 6), run (bit 5) and tap select (bits 2:0) from wdata. Bit 4 always reads 1 and bit 3 always reads 0.
- R3: While run is 0, the counter reads 0x00 and ignores writes. While run is 1, a write to address 1 loads wdata[7:0] only when wdata[15:8] is 0x5A.
- R4: While run is 1, the counter steps by one every 2^k system clock cycles. For tap codes 0 to 7, k is 1, 5, 6, 7, 8, 9, 11 and 12 respectively.
- R5: The overflow flag (bit 7) sets in the cycle in which the counter steps from 0xFF to 0x00.
- R6: A write to address 0 with bit 7 equal to 0 clears the flag only if an earlier read of address 0 returned the flag as 1. A write with bit 7 equal to 1 never changes the flag.
- R7: An overflow that occurs after the arming read cancels that arming. An overflow in the same cycle as a clearing write leaves the flag set.
- R8: With mode 0 (interval), irq_o equals the flag, and rst_req_o stays 0.
- R9: With mode 1 (watchdog), each overflow drives rst_req_o high for exactly one cycle, and irq_o stays 0.
- R10: A cycle with standby_i at 1 clears the flag, the mode bit and the run bit, and leaves the tap select unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby_i | input | 1 | Standby entry; partially clears the control register |
| bus_addr | input | 1 | 0 selects the control/status register, 1 selects the counter |
| bus_rd | input | 1 | Read strobe; arms the flag clear when the flag is seen as 1 |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Key in bits 15:8, data in bits 7:0 |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq_o | output | 1 | Interval-mode interrupt request (level) |
| rst_req_o | output | 1 | Watchdog-mode reset request (one-cycle pulse) |

## Verification
Several rules are checked by the in-line assertions on every cycle:

- the counter sits at zero while stopped, holds between ticks and wraps to zero on overflow;
- the flag sets on every wrap and never drops while it is unarmed;
- standby clears the upper control bits and keeps the tap select;
- the reset request never lasts more than one cycle.

Other rules can only be shown by the bench's scenarios:

- key rejection on both registers;
- the exact step period for each tested tap code;
- the read-then-write clearing sequence, including loss of the arming after a fresh overflow;
- how the two modes route an overflow to irq_o or to rst_req_o.

// File: rtl/gtmr_pkg.sv
// Shared constants and helpers for the guarded overflow timer.
// Assumes an 8-bit counter and an 8-bit control/status register.
package gtmr_pkg;
    localparam int CNT_W     = 8;
    localparam int DATA_W    = 8;
    localparam int KEY_W     = 8;
    localparam int SEL_W     = 3;
    localparam int NUM_TAPS  = 1 << SEL_W;
    localparam logic [KEY_W-1:0] KEY_CSR = 8'hA5;
    localparam logic [KEY_W-1:0] KEY_CNT = 8'h5A;
    localparam logic ADDR_CSR = 1'b0;
    localparam logic ADDR_CNT = 1'b1;
    // bit positions inside the control/status register
    localparam int B_FLAG = 7;
    localparam int B_MODE = 6;
    localparam int B_RUN  = 5;
    localparam int B_RSV1 = 4;
    localparam int B_RSV0 = 3;

    // log2 of the prescaler ratio for each tap code
    function automatic int tap_log2(input int code);
        case (code)
            0: return 1;
            1: return 5;
            2: return 6;
            3: return 7;
            4: return 8;
            5: return 9;
            6: return 11;
            default: return 12;
        endcase
    endfunction

    localparam int PRE_W = tap_log2(NUM_TAPS - 1);
endpackage

// File: rtl/gtmr_prescaler.sv
// Free-running prescaler. It produces one enable pulse every 2^k cycles
// on the tap that sel_i picks. It assumes the tap ratios are powers of two,
// so each tap is an AND of the low bits of a single counter.
module gtmr_prescaler
    import gtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    logic [PRE_W-1:0]    pre_q;
    logic [NUM_TAPS-1:0] taps;

    // free-running divide chain
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // one pulse per tap when its low bits are all ones
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int L = tap_log2(g);
        assign taps[g] = &pre_q[L-1:0];
    end

    assign tick_o = taps[sel_i];
endmodule

// File: rtl/gtmr_counter.sv
// The 8-bit timer counter. It is held at zero while run is low. Keyed bus
// writes load it, and prescaler ticks step it. It flags a wrap from all ones
// to zero. It assumes the run input is registered.
module gtmr_counter
    import gtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             bus_addr,
    input  logic             bus_wr,
    input  logic [15:0]      bus_wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             ld;

    assign ld    = bus_wr && (bus_addr == ADDR_CNT) && (bus_wdata[15:8] == KEY_CNT);
    assign ovf_o = run_i && !ld && tick_i && (cnt_q == {CNT_W{1'b1}});
    assign cnt_o = cnt_q;

    // count, load or hold at zero
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) cnt_q <= '0;
        else if (ld)          cnt_q <= bus_wdata[CNT_W-1:0];
        else if (tick_i)      cnt_q <= cnt_q + 1'b1;
    end

    // R3
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));
    // R4
    step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !ld && !tick_i) |=> $stable(cnt_q));
    // R5
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (cnt_q == '0));
endmodule

// File: rtl/gtmr_csr.sv
// Control/status register. It holds the overflow flag with its read-armed
// clear, the mode, run and tap select fields, and the request outputs. It
// assumes ovf_i is a single-cycle pulse from the counter.
module gtmr_csr
    import gtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_i,
    input  logic              ovf_i,
    input  logic              bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    output logic [DATA_W-1:0] csr_o,
    output logic              run_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              irq_o,
    output logic              rst_req_o
);
    logic             flag_q, mode_q, run_q, armed_q, rreq_q;
    logic [SEL_W-1:0] sel_q;
    logic             wr_ok, rd_csr, clr;
    logic             unused_bits;

    assign wr_ok       = bus_wr && (bus_addr == ADDR_CSR) && (bus_wdata[15:8] == KEY_CSR);
    assign rd_csr      = bus_rd && (bus_addr == ADDR_CSR);
    assign clr         = wr_ok && !bus_wdata[B_FLAG] && armed_q;
    assign unused_bits = ^bus_wdata[B_RSV1:B_RSV0];

    // flag and its arming, with overflow taking priority
    always_ff @(posedge clk) begin
        if (!rst_n || standby_i) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (ovf_i) begin
            flag_q  <= 1'b1;
            armed_q <= 1'b0;
        end else if (clr) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (rd_csr && flag_q) begin
            armed_q <= 1'b1;
        end
    end

    // mode and run fields, which standby clears
    always_ff @(posedge clk) begin
        if (!rst_n || standby_i) begin
            mode_q <= 1'b0;
            run_q  <= 1'b0;
        end else if (wr_ok) begin
            mode_q <= bus_wdata[B_MODE];
            run_q  <= bus_wdata[B_RUN];
        end
    end

    // tap select, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)     sel_q <= '0;
        else if (wr_ok) sel_q <= bus_wdata[SEL_W-1:0];
    end

    // one-cycle watchdog reset request
    always_ff @(posedge clk) begin
        if (!rst_n || standby_i) rreq_q <= 1'b0;
        else                     rreq_q <= ovf_i && mode_q;
    end

    assign csr_o     = {flag_q, mode_q, run_q, 1'b1, 1'b0, sel_q};
    assign run_o     = run_q;
    assign sel_o     = sel_q;
    assign irq_o     = flag_q && !mode_q;
    assign rst_req_o = rreq_q;

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_i && !standby_i) |=> flag_q);
    // R6
    no_unarmed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !armed_q && !standby_i) |=> flag_q);
    // R7
    ovf_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_i && clr && !standby_i) |=> flag_q);
    // R10
    standby_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> (!flag_q && !mode_q && !run_q && $stable(sel_q)));
    // R9
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rreq_q |=> !rreq_q);
endmodule

// File: rtl/guard_timer.sv
// Top of the guarded overflow timer. It wires the prescaler, counter and
// control/status register together and muxes the read data. It assumes a
// bus that drives at most one strobe per cycle.
module guard_timer
    import gtmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        standby_i,
    input  logic        bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq_o,
    output logic        rst_req_o
);
    logic              tick, run, ovf;
    logic [SEL_W-1:0]  sel;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] csr;

    gtmr_prescaler u_pre (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .tick_o(tick)
    );

    gtmr_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .cnt_o(cnt), .ovf_o(ovf)
    );

    gtmr_csr u_csr (
        .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .ovf_i(ovf),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .csr_o(csr), .run_o(run), .sel_o(sel),
        .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    // read data select by address
    always_comb begin
        bus_rdata = (bus_addr == ADDR_CNT) ? cnt : csr;
    end

    // R8
    irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> !irq_o);
endmodule

// File: tb/guard_timer_tb.sv
module guard_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby_i = 1'b0;
    logic        bus_addr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_o, rst_req_o;

    int    n_total = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    int    exp_q[$];
    string tag_q[$];
    event  smp;

    always #2.5 clk = ~clk;

    guard_timer u_dut (
        .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: compares read data against the queued expectation
    always @(smp) begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(bus_rdata == e[7:0], t, bus_rdata, e);
    end

    task automatic raw_wr(input logic a, input logic [7:0] key, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = {key, d}; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic csr_wr(input logic [7:0] d);
        raw_wr(1'b0, 8'hA5, d);
    endtask

    // driver: pushes the expected value, then performs the strobed read
    task automatic rd_exp(input logic a, input int e, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        #1 -> smp;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        summary();
    end

    initial begin
        int ratios[8] = '{2, 32, 64, 128, 256, 512, 2048, 4096};
        int codes[3]  = '{0, 1, 6};
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        rd_exp(1'b0, 8'h10, "R1 csr");
        rd_exp(1'b1, 8'h00, "R1 cnt");
        @(negedge clk);
        check(!irq_o && !rst_req_o, "R1 requests", {irq_o, rst_req_o}, 0);

        // R2 keyed writes and fixed reserved bits
        raw_wr(1'b0, 8'h3C, 8'h67);
        rd_exp(1'b0, 8'h10, "R2 bad key");
        csr_wr(8'hCE);
        rd_exp(1'b0, 8'h56, "R2 fields");
        csr_wr(8'h0B);
        rd_exp(1'b0, 8'h13, "R2 rewrite");

        // R3 counter stays at zero while stopped; keyed load while running
        raw_wr(1'b1, 8'h5A, 8'h40);
        rd_exp(1'b1, 8'h00, "R3 stopped");
        csr_wr(8'h20);
        raw_wr(1'b1, 8'h11, 8'hF0);
        @(negedge clk); bus_addr = 1'b1; #0.5;
        check(bus_rdata < 8'h40, "R3 bad key", bus_rdata, 8'h40);
        raw_wr(1'b1, 8'h5A, 8'h80);
        rd_exp(1'b1, 8'h80, "R3 load");

        // R4 step period for several tap codes
        foreach (codes[i]) begin
            logic [7:0] v;
            int n;
            csr_wr(8'h20 | codes[i][7:0]);
            bus_addr = 1'b1;
            @(negedge clk); v = bus_rdata;
            do @(negedge clk); while (bus_rdata == v);
            v = bus_rdata; n = 0;
            do begin @(negedge clk); n++; end while (bus_rdata == v);
            check(n == ratios[codes[i]], "R4 period", n, ratios[codes[i]]);
        end

        // R5/R8 interval overflow raises irq, no reset request
        begin
            bit seen_rr = 0;
            csr_wr(8'h20);
            raw_wr(1'b1, 8'h5A, 8'hFD);
            for (int k = 0; k < 20 && !irq_o; k++) begin
                @(negedge clk); if (rst_req_o) seen_rr = 1;
            end
            check(irq_o, "R8 irq", irq_o, 1);
            check(!seen_rr, "R8 no reset req", seen_rr, 0);
        end
        // R6 write 0 without arming read, write 1, then armed clear
        csr_wr(8'h20);
        rd_exp(1'b0, 8'hB0, "R6 unarmed write");
        csr_wr(8'hA0);
        rd_exp(1'b0, 8'hB0, "R6 write one");
        csr_wr(8'h20);
        rd_exp(1'b0, 8'h30, "R6 armed clear");
        @(negedge clk);
        check(!irq_o, "R8 irq follows flag", irq_o, 0);

        // R7 a fresh overflow cancels arming
        raw_wr(1'b1, 8'h5A, 8'hFD);
        for (int k = 0; k < 20 && !irq_o; k++) @(negedge clk);
        rd_exp(1'b0, 8'hB0, "R5 flag set");
        raw_wr(1'b1, 8'h5A, 8'hFD);
        repeat (12) @(negedge clk);
        csr_wr(8'h20);
        rd_exp(1'b0, 8'hB0, "R7 disarmed");
        csr_wr(8'h20);
        rd_exp(1'b0, 8'h30, "R7 rearmed clear");

        // R9 watchdog pulse
        begin
            int w = 0;
            csr_wr(8'h60);
            raw_wr(1'b1, 8'h5A, 8'hFD);
            for (int k = 0; k < 20 && !rst_req_o; k++) @(negedge clk);
            check(rst_req_o, "R9 pulse", rst_req_o, 1);
            check(!irq_o, "R9 no irq", irq_o, 0);
            @(negedge clk); w = rst_req_o;
            check(w == 0, "R9 one cycle", w, 0);
        end
        rd_exp(1'b0, 8'hF0, "R5 watchdog flag");

        // R10 standby partial clear
        csr_wr(8'h65);
        @(negedge clk); standby_i = 1'b1;
        @(posedge clk); #1 standby_i = 1'b0;
        rd_exp(1'b0, 8'h15, "R10 csr");
        rd_exp(1'b1, 8'h00, "R10 cnt");

        @(negedge clk);
        summary();
    end
endmodule